// File: doc/BRIEF.md
# USB Endpoint Buffer State Controller

This block keeps track of which buffer each physical endpoint of a USB device controller owns, for a controller with thirty physical endpoints. Every endpoint has two buffers, each with an Active flag. It also has a pointer that names the buffer the hardware works on now, and a configuration bit that selects single or double buffering. Firmware reaches the block over a small register bus with a write strobe, an address and write data. Reads are combinational. Firmware marks buffers Active through a separate write-1-to-set port. The USB engine reports finished transfers and skip acknowledgements as one-cycle pulses, one bit per endpoint.

When a transfer finishes, the current buffer goes inactive. On a double-buffered endpoint the pointer then moves to the other buffer. Firmware can also ask for a skip, which takes the current buffer away from the hardware. A skip deactivates only the buffer the pointer selects and never moves the pointer. Whenever an Active flag drops, a sticky per-endpoint status bit is set. A single interrupt line reports the status bits that are enabled.

All event inputs are one-cycle pulses that the block always accepts. There is no back-pressure on any port, and the register bus never stalls.

Top module: `usb_ep_buf_ctrl`

## Requirements
- R1: After reset, all Active flags, skip requests, buffer pointers, configuration, status and enable bits are 0, and `irq` is 0.
- R2: Writing to offset 0x14 sets each skip bit written as 1. Bits written as 0 keep their value. Reading 0x14 returns the pending skip bits in bits 29:0, and bits 31:30 always read as 0.
- R3: While a skip bit is pending, a `skip_ack` pulse for that endpoint clears the Active flag of the buffer the pointer selects and clears the skip bit on the same edge. It leaves the pointer (offset 0x18) unchanged.
- R4: A pending skip on an endpoint whose selected buffer is not Active clears on the next edge without any `skip_ack`, and it sets no status bit.
- R5: A `xfer_done` pulse on an endpoint whose selected buffer is Active clears that flag. It toggles the pointer only if the endpoint is double-buffered. A pulse on an endpoint whose selected buffer is inactive has no effect.
- R6: Offset 0x1C is read/write in bits 29:2, where 0 means single and 1 means double buffering. Offset 0x18 is read-only, with 0 meaning buffer 0 and 1 meaning buffer 1. In both registers bits 1:0 and 31:30 read as 0.
- R7: Any Active flag falling from 1 to 0 sets that endpoint's bit in the status register at 0x20. Writing 1 clears a bit, and a new fall in the same cycle wins over the clear.
- R8: The enable register at 0x24 is read/write in bits 29:0. `irq` is high exactly when some status bit and its enable bit are both 1.
- R9: If a completion and a skip act on one endpoint in the same cycle, the completion is applied first. The skip then acts on the buffer selected after any toggle.
- R10: A 1 on `act_set0[i]` or `act_set1[i]` sets that Active flag, and it wins over a clear in the same cycle. The flags are visible on `act0` and `act1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| act_set0 | input | 30 | Set Active flag of buffer 0, per endpoint |
| act_set1 | input | 30 | Set Active flag of buffer 1, per endpoint |
| xfer_done | input | 30 | Transfer completion pulse per endpoint |
| skip_ack | input | 30 | Skip acknowledgement pulse per endpoint |
| skip_req | output | 30 | Pending skip requests toward the engine |
| act0 | output | 30 | Active flags of buffer 0 |
| act1 | output | 30 | Active flags of buffer 1 |
| irq | output | 1 | Combined masked interrupt |

## Verification
A completion and a skip can fall on the same endpoint in the same cycle. That case is provoked on purpose: a directed case drives `xfer_done` and `skip_ack` together on a double-buffered endpoint with both buffers Active. The random phase also lets both pulses land together across all endpoints. The result is judged against a bench model that first applies the completion, including any pointer toggle, and then clears the buffer the new pointer selects. The same check is made on `act0`, `act1`, `skip_req`, the pointer register and the status bits.

// File: rtl/usb_epb_pkg.sv
package usb_epb_pkg;
  localparam logic [7:0] OFS_SKIP  = 8'h14;
  localparam logic [7:0] OFS_INUSE = 8'h18;
  localparam logic [7:0] OFS_CFG   = 8'h1C;
  localparam logic [7:0] OFS_STS   = 8'h20;
  localparam logic [7:0] OFS_EN    = 8'h24;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_SKIP, SEL_INUSE, SEL_CFG, SEL_STS, SEL_EN
  } reg_sel_e;

  function automatic reg_sel_e decode(input logic [7:0] a);
    case (a)
      OFS_SKIP:  decode = SEL_SKIP;
      OFS_INUSE: decode = SEL_INUSE;
      OFS_CFG:   decode = SEL_CFG;
      OFS_STS:   decode = SEL_STS;
      OFS_EN:    decode = SEL_EN;
      default:   decode = SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/epb_slot.sv
module epb_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic dbl,
  input  logic done,
  input  logic skip_wr,
  input  logic skip_ack,
  input  logic set0,
  input  logic set1,
  output logic act0,
  output logic act1,
  output logic inuse,
  output logic skip_pend,
  output logic fall
);
  logic a0_q, a1_q, u_q, sk_q;
  logic a0_d, a1_d, u_d, sk_d;

  always_comb begin
    a0_d = a0_q;
    a1_d = a1_q;
    u_d  = u_q;
    sk_d = sk_q;
    // completion goes first
    if (done && (u_q ? a1_q : a0_q)) begin
      if (u_q) a1_d = 1'b0;
      else     a0_d = 1'b0;
      if (dbl) u_d = ~u_q;
    end
    // skip acts on the buffer chosen after completion
    if (sk_q && (skip_ack || !(u_d ? a1_d : a0_d))) begin
      if (u_d) a1_d = 1'b0;
      else     a0_d = 1'b0;
      sk_d = 1'b0;
    end
    if (skip_wr) sk_d = 1'b1;
    a0_d = a0_d | set0;
    a1_d = a1_d | set1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a0_q <= 1'b0;
      a1_q <= 1'b0;
      u_q  <= 1'b0;
      sk_q <= 1'b0;
    end else begin
      a0_q <= a0_d;
      a1_q <= a1_d;
      u_q  <= u_d;
      sk_q <= sk_d;
    end
  end

  assign act0      = a0_q;
  assign act1      = a1_q;
  assign inuse     = u_q;
  assign skip_pend = sk_q;
  assign fall      = (a0_q & ~a0_d) | (a1_q & ~a1_d);
endmodule

// File: rtl/epb_regs.sv
module epb_regs
  import usb_epb_pkg::*;
#(
  parameter int NUM_EP  = 30,
  parameter int CTRL_EP = 2,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [7:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NUM_EP-1:0] skip_vec,
  input  logic [NUM_EP-1:0] inuse_vec,
  input  logic [NUM_EP-1:0] sts_vec,
  output logic [NUM_EP-1:0] cfg,
  output logic [NUM_EP-1:0] en,
  output logic [NUM_EP-1:0] skip_wr,
  output logic [NUM_EP-1:0] sts_clr,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [NUM_EP-1:0] CFG_MASK = ~NUM_EP'((1 << CTRL_EP) - 1);

  reg_sel_e          sel;
  logic [NUM_EP-1:0] wbits;

  assign sel     = decode(addr);
  assign wbits   = wdata[NUM_EP-1:0];
  assign skip_wr = (wr && sel == SEL_SKIP) ? wbits : '0;
  assign sts_clr = (wr && sel == SEL_STS)  ? wbits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0;
      en  <= '0;
    end else if (wr) begin
      if (sel == SEL_CFG) cfg <= wbits & CFG_MASK;
      if (sel == SEL_EN)  en  <= wbits;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_SKIP:  rdata = DATA_W'(skip_vec);
      SEL_INUSE: rdata = DATA_W'(inuse_vec & CFG_MASK);
      SEL_CFG:   rdata = DATA_W'(cfg);
      SEL_STS:   rdata = DATA_W'(sts_vec);
      SEL_EN:    rdata = DATA_W'(en);
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/epb_irq.sv
module epb_irq #(
  parameter int NUM_EP = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EP-1:0] fall,
  input  logic [NUM_EP-1:0] clr,
  input  logic [NUM_EP-1:0] en,
  output logic [NUM_EP-1:0] sts,
  output logic              irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) sts <= '0;
    else        sts <= (sts & ~clr) | fall;
  end
  assign irq = |(sts & en);
endmodule

// File: rtl/usb_ep_buf_ctrl.sv
module usb_ep_buf_ctrl #(
  parameter int NUM_EP  = 30,
  parameter int CTRL_EP = 2,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [7:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NUM_EP-1:0] act_set0,
  input  logic [NUM_EP-1:0] act_set1,
  input  logic [NUM_EP-1:0] xfer_done,
  input  logic [NUM_EP-1:0] skip_ack,
  output logic [NUM_EP-1:0] skip_req,
  output logic [NUM_EP-1:0] act0,
  output logic [NUM_EP-1:0] act1,
  output logic              irq
);
  logic [NUM_EP-1:0] cfg, en, skip_wr, sts_clr, sts, inuse, fall;

  epb_regs #(.NUM_EP(NUM_EP), .CTRL_EP(CTRL_EP), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .skip_vec(skip_req), .inuse_vec(inuse), .sts_vec(sts),
    .cfg(cfg), .en(en), .skip_wr(skip_wr), .sts_clr(sts_clr), .rdata(reg_rdata)
  );

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    epb_slot u_slot (
      .clk(clk), .rst_n(rst_n), .dbl(cfg[i]), .done(xfer_done[i]),
      .skip_wr(skip_wr[i]), .skip_ack(skip_ack[i]),
      .set0(act_set0[i]), .set1(act_set1[i]),
      .act0(act0[i]), .act1(act1[i]), .inuse(inuse[i]),
      .skip_pend(skip_req[i]), .fall(fall[i])
    );
  end

  epb_irq #(.NUM_EP(NUM_EP)) u_irq (
    .clk(clk), .rst_n(rst_n), .fall(fall), .clr(sts_clr), .en(en),
    .sts(sts), .irq(irq)
  );
endmodule

// File: rtl/epb_chk.sv
module epb_chk #(
  parameter int NUM_EP  = 30,
  parameter int CTRL_EP = 2,
  parameter int DATA_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_EP-1:0] inuse,
  input logic [NUM_EP-1:0] cfg,
  input logic [NUM_EP-1:0] xfer_done,
  input logic [NUM_EP-1:0] act0,
  input logic [NUM_EP-1:0] act1,
  input logic [NUM_EP-1:0] sts,
  input logic [NUM_EP-1:0] en,
  input logic              irq,
  input logic [DATA_W-1:0] reg_rdata
);
  logic past_ok;
  always_ff @(posedge clk) past_ok <= rst_n;

  AST_SKIP_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (((inuse ^ $past(inuse)) & ~$past(xfer_done)) == '0)); // R3
  AST_SINGLE_NO_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (((inuse ^ $past(inuse)) & ~$past(cfg)) == '0)); // R5
  AST_CTRL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    inuse[CTRL_EP-1:0] == '0); // R6
  AST_FALL_SETS_STS: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (((($past(act0) & ~act0) | ($past(act1) & ~act1)) & ~sts) == '0)); // R7
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((sts & en) != '0)); // R8
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATA_W-1:NUM_EP] == '0); // R2
endmodule

bind usb_ep_buf_ctrl epb_chk #(.NUM_EP(NUM_EP), .CTRL_EP(CTRL_EP), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .inuse(inuse), .cfg(cfg), .xfer_done(xfer_done),
  .act0(act0), .act1(act1), .sts(sts), .en(en), .irq(irq), .reg_rdata(reg_rdata)
);

// File: tb/sim_usb_ep_buf_ctrl.sv
module sim_usb_ep_buf_ctrl;
  localparam int N = 30;
  localparam logic [N-1:0] CMASK = ~N'(3);

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_addr = 8'h0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [N-1:0] act_set0 = '0, act_set1 = '0, xfer_done = '0, skip_ack = '0;
  logic [N-1:0] skip_req, act0, act1;
  logic irq;

  logic [N-1:0] m_a0, m_a1, m_u, m_sk, m_cfg, m_sts, m_en;
  int checks = 0, fails = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  usb_ep_buf_ctrl u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic mdl_reset();
    m_a0 = '0; m_a1 = '0; m_u = '0; m_sk = '0;
    m_cfg = '0; m_sts = '0; m_en = '0;
  endtask

  // model of one clock edge, from the requirements
  task automatic mdl_edge();
    logic [N-1:0] swr, clr, fl;
    logic a0, a1, u, sk;
    swr = (reg_wr && reg_addr == 8'h14) ? reg_wdata[N-1:0] : '0;
    clr = (reg_wr && reg_addr == 8'h20) ? reg_wdata[N-1:0] : '0;
    fl = '0;
    for (int i = 0; i < N; i++) begin
      a0 = m_a0[i]; a1 = m_a1[i]; u = m_u[i]; sk = m_sk[i];
      if (xfer_done[i] && (u ? a1 : a0)) begin
        if (u) a1 = 0; else a0 = 0;
        if (m_cfg[i]) u = ~u;
      end
      if (sk && (skip_ack[i] || !(u ? a1 : a0))) begin
        if (u) a1 = 0; else a0 = 0;
        sk = 0;
      end
      if (swr[i]) sk = 1;
      a0 |= act_set0[i]; a1 |= act_set1[i];
      fl[i] = (m_a0[i] & ~a0) | (m_a1[i] & ~a1);
      m_a0[i] = a0; m_a1[i] = a1; m_u[i] = u; m_sk[i] = sk;
    end
    m_sts = (m_sts & ~clr) | fl;
    if (reg_wr && reg_addr == 8'h1C) m_cfg = reg_wdata[N-1:0] & CMASK;
    if (reg_wr && reg_addr == 8'h24) m_en = reg_wdata[N-1:0];
  endtask

  task automatic step();
    @(posedge clk);
    if (rst_n) mdl_edge();
    @(negedge clk);
  endtask

  task automatic outs(input string tag);
    chk({tag, " act0"}, 32'(act0), 32'(m_a0));
    chk({tag, " act1"}, 32'(act1), 32'(m_a1));
    chk({tag, " skip_req"}, 32'(skip_req), 32'(m_sk));
    chk({tag, " irq"}, 32'(irq), 32'(|(m_sts & m_en)));
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a; #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic clr_in();
    reg_wr = 0; act_set0 = '0; act_set1 = '0; xfer_done = '0; skip_ack = '0;
  endtask

  task automatic wr1(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d; step(); reg_wr = 0;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    mdl_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    outs("R1");
    rd(8'h14, 0, "R1 skip"); rd(8'h18, 0, "R1 inuse"); rd(8'h1C, 0, "R1 cfg");
    rd(8'h20, 0, "R1 sts"); rd(8'h24, 0, "R1 en");
    // R2: writing zero has no effect
    wr1(8'h14, 32'h0); chk("R2 zero write", 32'(skip_req), 0);
    // R4: skip on idle endpoint self-clears, no status
    wr1(8'h14, 32'hC000_0020); chk("R2 skip set", 32'(skip_req), 32'h20);
    rd(8'h14, 32'h20, "R2 readback");
    step(); chk("R4 self clear", 32'(skip_req), 0); rd(8'h20, 0, "R4 no status");
    // R10 + R5 single buffered
    act_set0[5] = 1; step(); clr_in(); chk("R10 set", 32'(act0), 32'h20);
    xfer_done[5] = 1; act_set0[6] = 1; step(); clr_in();
    chk("R5 single clear", 32'(act0), 32'h40); rd(8'h18, 0, "R5 single no toggle");
    rd(8'h20, 32'h20, "R7 sts set");
    // R5: done on inactive buffer ignored
    xfer_done[7] = 1; step(); xfer_done = '0; rd(8'h18, 0, "R5 idle done ignored");
    // R8 enable
    wr1(8'h24, 32'h20); chk("R8 irq on", 32'(irq), 1);
    wr1(8'h20, 32'h20); chk("R7 w1c", 32'(irq), 0); rd(8'h20, 0, "R7 cleared");
    // R10: set wins over completion clear
    xfer_done[6] = 1; act_set0[6] = 1; step(); clr_in();
    chk("R10 set wins", 32'(act0), 32'h40); rd(8'h20, 0, "R10 no fall");
    // R6 config
    wr1(8'h1C, 32'hFFFF_FFFF); rd(8'h1C, 32'h3FFF_FFFC, "R6 cfg mask");
    wr1(8'h1C, 32'h0000_0380); rd(8'h1C, 32'h380, "R6 cfg rw");
    // R5 double buffered on ep7
    act_set0[7] = 1; act_set1[7] = 1; step(); clr_in();
    xfer_done[7] = 1; step(); clr_in();
    rd(8'h18, 32'h80, "R5 toggle"); chk("R5 dbl act0", 32'(act0 & 32'h80), 0);
    xfer_done[7] = 1; step(); clr_in();
    rd(8'h18, 0, "R5 toggle back"); chk("R5 dbl act1", 32'(act1 & 32'h80), 0);
    // R3 skip with ack on ep7, pointer stays
    act_set0[7] = 1; act_set1[7] = 1; step(); clr_in();
    wr1(8'h14, 32'h80); step(); chk("R3 pending", 32'(skip_req), 32'h80);
    skip_ack[7] = 1; step(); clr_in();
    chk("R3 act0 cleared", 32'(act0 & 32'h80), 0);
    chk("R3 act1 kept", 32'(act1 & 32'h80), 32'h80);
    chk("R3 skip cleared", 32'(skip_req), 0); rd(8'h18, 0, "R3 ptr kept");
    // R9 completion and skip together on ep8
    act_set0[8] = 1; act_set1[8] = 1; step(); clr_in();
    wr1(8'h14, 32'h100);
    xfer_done[8] = 1; skip_ack[8] = 1; step(); clr_in();
    chk("R9 both cleared", 32'((act0 | act1) & 32'h100), 0);
    rd(8'h18, 32'h100, "R9 ptr toggled");
    chk("R9 skip done", 32'(skip_req), 0);
    outs("R9 model");
    // random phase
    for (int c = 0; c < 4000; c++) begin
      act_set0 = N'($urandom) & N'($urandom) & N'($urandom);
      act_set1 = N'($urandom) & N'($urandom) & N'($urandom);
      xfer_done = N'($urandom) & N'($urandom);
      skip_ack = N'($urandom) & N'($urandom) & N'($urandom);
      reg_wr = ($urandom % 4) == 0;
      case ($urandom % 5)
        0: reg_addr = 8'h14; 1: reg_addr = 8'h1C; 2: reg_addr = 8'h20;
        3: reg_addr = 8'h24; default: reg_addr = 8'h18;
      endcase
      reg_wdata = (reg_addr == 8'h14) ? ($urandom & $urandom & $urandom) : $urandom;
      step(); clr_in();
      outs("R9 random");
      if (c % 8 == 0) begin
        rd(8'h18, 32'(m_u & CMASK), "R5 random inuse");
        rd(8'h20, 32'(m_sts), "R7 random sts");
        rd(8'h1C, 32'(m_cfg), "R6 random cfg");
      end
    end
    finish_run();
  end
endmodule